// File: doc/BRIEF.md
# GPS-Format Real-Time Clock

This block keeps time the way satellite navigation receivers count it: a week number, a count of seconds inside the current week, and a binary fraction of a second. A single-cycle `tick_en` pulse at 32768 Hz drives all of it. Week 0, second 0, fraction 0 is the zero point, and no leap-second correction is ever applied. A load strobe sets all three fields in one step. The fields themselves are the read data.

An alarm compares the seconds and fraction against programmed values and raises a sticky flag on a match. Because the compare covers the whole week, the alarm period can be as long as one week.

A second, independent down-timer runs alongside the clock. Its value has seconds in the upper bits and an 8-bit fraction of a second in the lowest 8 bits. It takes a full parallel load, counts toward zero, raises its own sticky flag when it gets there, and then stops.

Top module: `gps_rtc`

## Requirements
- R1: After a synchronous reset the following all read zero: week, seconds, fraction, timer value, alarm flag and timer flag. The alarm is also disarmed.
- R2: Each cycle with `tick_en` high and no time load advances the fraction by one. A cycle without `tick_en` leaves week, seconds and fraction unchanged.
- R3: The 15-bit fraction wraps from 32767 to 0 and increments the seconds count in the same clock edge. Seconds never reach 604800.
- R4: The seconds count wraps from 604799 to 0 and increments the week in the same edge. The 10-bit week wraps from 1023 to 0.
- R5: `time_ld` writes week, seconds and fraction together in one edge. A `tick_en` in that same cycle is discarded.
- R6: `alm_wr` stores `alm_sec`/`alm_frac` as the compare value, and its arm bit `alm_arm`. If the alarm is armed and a tick brings seconds and fraction to equal the compare value, `alm_flag` rises one clock after the counters first show that value. Reaching the value by `time_ld` does not set the flag.
- R7: `alm_flag` stays set until a cycle with `alm_clr`. If a set and a clear fall in the same cycle, the set wins.
- R8: While the alarm is disarmed (`alm_arm` written as 0), `alm_flag` never sets.
- R9: The timer value holds seconds in bits [23:8] and a 1/256-second fraction in bits [7:0]. It decrements by one once every 128 ticks. `tmr_ld` restarts that 128-tick prescaler.
- R10: The edge that brings the timer to zero also sets `tmr_flag`. The timer then holds at zero. `tmr_flag` stays set until a cycle with `tmr_clr`, and loading the timer does not clear it.
- R11: `tmr_ld` writes its full value in one edge even when `tick_en` is high in that cycle. That tick is discarded for the timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-cycle pulse at the 32768 Hz fraction rate |
| time_ld | input | 1 | Strobe: load week, seconds and fraction |
| ld_week | input | 10 | Week value to load |
| ld_sec | input | 20 | Seconds-of-week value to load (0..604799) |
| ld_frac | input | 15 | Fraction value to load |
| alm_wr | input | 1 | Strobe: write alarm compare value and arm bit |
| alm_arm | input | 1 | Arm bit written by `alm_wr` |
| alm_sec | input | 20 | Alarm seconds compare value |
| alm_frac | input | 15 | Alarm fraction compare value |
| alm_clr | input | 1 | Clear the alarm flag |
| tmr_ld | input | 1 | Strobe: parallel load of the timer |
| tmr_ld_val | input | 24 | Timer load value: seconds in [23:8], fraction in [7:0] |
| tmr_clr | input | 1 | Clear the timer flag |
| week | output | 10 | Current week number |
| sec | output | 20 | Current seconds of week |
| frac | output | 15 | Current fraction of a second |
| alm_flag | output | 1 | Sticky alarm flag |
| tmr_val | output | 24 | Current timer value |
| tmr_flag | output | 1 | Sticky timer-expired flag |

## Verification
The bench drives inputs after the falling edge and reads outputs at the next falling edge, one full clock later. Week, seconds, fraction and timer value, including every carry, are due at the first rising edge after a tick or a load, so they are compared at that falling edge. The alarm flag is due one edge later than the counters that match, so the bench checks that it is still low when the matching fraction first appears and high one cycle after that. The timer is counted through its 128-tick prescaler arithmetically, and the bench checks it on the last tick before a step and on the tick that makes the step.

// File: rtl/gps_rtc_pkg.sv
package gps_rtc_pkg;

  // Default geometry of the time base
  localparam int DEF_FRAC_W       = 15;
  localparam int DEF_SEC_PER_WEEK = 604800;
  localparam int DEF_WEEK_W       = 10;
  localparam int DEF_TFRAC_W      = 8;
  localparam int DEF_TSEC_W       = 16;

  // Down-timer run state
  typedef enum logic {
    TMR_STOPPED  = 1'b0,
    TMR_COUNTING = 1'b1
  } tmr_state_e;

endpackage

// File: rtl/gps_rtc_tod.sv
module gps_rtc_tod #(
  parameter int FRAC_W       = 15,
  parameter int SEC_PER_WEEK = 604800,
  parameter int SEC_W        = 20,
  parameter int WEEK_W       = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              ld,
  input  logic [WEEK_W-1:0] ld_week,
  input  logic [SEC_W-1:0]  ld_sec,
  input  logic [FRAC_W-1:0] ld_frac,
  output logic [WEEK_W-1:0] week,
  output logic [SEC_W-1:0]  sec,
  output logic [FRAC_W-1:0] frac,
  output logic              adv
);

  localparam logic [FRAC_W-1:0] FRAC_LAST = {FRAC_W{1'b1}};
  localparam logic [SEC_W-1:0]  SEC_LAST  = SEC_W'(SEC_PER_WEEK - 1);
  localparam logic [FRAC_W-1:0] FRAC_ONE  = FRAC_W'(1);
  localparam logic [SEC_W-1:0]  SEC_ONE   = SEC_W'(1);
  localparam logic [WEEK_W-1:0] WEEK_ONE  = WEEK_W'(1);

  logic frac_wrap;
  logic sec_wrap;

  assign frac_wrap = (frac == FRAC_LAST);
  assign sec_wrap  = (sec == SEC_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      week <= '0;
      sec  <= '0;
      frac <= '0;
      adv  <= 1'b0;
    end else begin
      adv <= 1'b0;
      if (ld) begin
        week <= ld_week;
        sec  <= ld_sec;
        frac <= ld_frac;
      end else if (tick_en) begin
        adv <= 1'b1;
        if (frac_wrap) begin
          frac <= '0;
          if (sec_wrap) begin
            sec  <= '0;
            week <= week + WEEK_ONE;
          end else begin
            sec <= sec + SEC_ONE;
          end
        end else begin
          frac <= frac + FRAC_ONE;
        end
      end
    end
  end

  // R2: a tick moves the fraction by exactly one, modulo its width
  assert_frac_step_R2: assert property (@(posedge clk) disable iff (rst)
    (tick_en && !ld) |=> (frac == $past(frac) + FRAC_ONE));

  // R2: no tick and no load keeps all of the time
  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!tick_en && !ld) |=> ($stable(frac) && $stable(sec) && $stable(week)));

  // R3: seconds stay inside the week
  assert_sec_range_R3: assert property (@(posedge clk) disable iff (rst)
    (!ld) |=> (sec < SEC_LAST + SEC_ONE));

  // R4: a week change only comes from a seconds wrap or a load
  assert_week_carry_R4: assert property (@(posedge clk) disable iff (rst)
    (!ld && !(tick_en && frac_wrap && sec_wrap)) |=> $stable(week));

  // R5: the load is taken in full, the tick dropped
  assert_load_R5: assert property (@(posedge clk) disable iff (rst)
    ld |=> (week == $past(ld_week) && sec == $past(ld_sec) && frac == $past(ld_frac)));

endmodule

// File: rtl/gps_rtc_alarm.sv
module gps_rtc_alarm #(
  parameter int FRAC_W = 15,
  parameter int SEC_W  = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  input  logic [SEC_W-1:0]  sec,
  input  logic [FRAC_W-1:0] frac,
  input  logic              wr,
  input  logic              wr_arm,
  input  logic [SEC_W-1:0]  wr_sec,
  input  logic [FRAC_W-1:0] wr_frac,
  input  logic              clr,
  output logic              flag
);

  logic [SEC_W-1:0]  cmp_sec;
  logic [FRAC_W-1:0] cmp_frac;
  logic              armed;
  logic              hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_sec  <= '0;
      cmp_frac <= '0;
      armed    <= 1'b0;
    end else if (wr) begin
      cmp_sec  <= wr_sec;
      cmp_frac <= wr_frac;
      armed    <= wr_arm;
    end
  end

  // adv marks counters that a tick just changed
  assign hit = armed && adv && (sec == cmp_sec) && (frac == cmp_frac);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag <= 1'b0;
    end else if (hit) begin
      flag <= 1'b1;
    end else if (clr) begin
      flag <= 1'b0;
    end
  end

  // R7: flag is sticky without a clear
  assert_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (flag && !clr) |=> flag);

  // R8: a disarmed alarm never raises the flag
  assert_disarmed_R8: assert property (@(posedge clk) disable iff (rst)
    (!armed && !flag) |=> !flag);

  // R6: flag rises only after a tick-driven advance
  assert_rise_after_tick_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(flag) |-> $past(adv));

endmodule

// File: rtl/gps_rtc_timer.sv
module gps_rtc_timer
  import gps_rtc_pkg::*;
#(
  parameter int FRAC_W  = 15,
  parameter int TFRAC_W = 8,
  parameter int TSEC_W  = 16,
  localparam int TMR_W  = TSEC_W + TFRAC_W,
  localparam int PRE_W  = FRAC_W - TFRAC_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  input  logic             ld,
  input  logic [TMR_W-1:0] ld_val,
  input  logic             clr,
  output logic [TMR_W-1:0] val,
  output logic             flag
);

  localparam logic [TMR_W-1:0] VAL_ONE = TMR_W'(1);

  logic       step;
  tmr_state_e state;

  generate
    if (PRE_W == 0) begin : g_nodiv
      assign step = tick_en && !ld;
    end else begin : g_div
      logic [PRE_W-1:0] pre;
      always_ff @(posedge clk) begin
        if (rst || ld) begin
          pre <= '0;
        end else if (tick_en) begin
          pre <= pre + PRE_W'(1);
        end
      end
      assign step = tick_en && !ld && (pre == {PRE_W{1'b1}});
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      val   <= '0;
      state <= TMR_STOPPED;
    end else if (ld) begin
      val   <= ld_val;
      state <= (ld_val != '0) ? TMR_COUNTING : TMR_STOPPED;
    end else if (step && state == TMR_COUNTING) begin
      val <= val - VAL_ONE;
      if (val == VAL_ONE) begin
        state <= TMR_STOPPED;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag <= 1'b0;
    end else if (!ld && step && state == TMR_COUNTING && val == VAL_ONE) begin
      flag <= 1'b1;
    end else if (clr) begin
      flag <= 1'b0;
    end
  end

  // R10: once at zero the timer stays there until reloaded
  assert_stop_at_zero_R10: assert property (@(posedge clk) disable iff (rst)
    (val == '0 && !ld) |=> (val == '0));

  // R10: the flag only rises as the value lands on zero
  assert_flag_at_zero_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(flag) |-> (val == '0));

  // R11: the load value is taken whatever the tick does
  assert_load_R11: assert property (@(posedge clk) disable iff (rst)
    ld |=> (val == $past(ld_val)));

  // R9: the value moves by at most one per edge
  assert_step_R9: assert property (@(posedge clk) disable iff (rst)
    (!ld && val != '0) |=> (val == $past(val) || val == $past(val) - VAL_ONE));

endmodule

// File: rtl/gps_rtc.sv
module gps_rtc
  import gps_rtc_pkg::*;
#(
  parameter int FRAC_W       = DEF_FRAC_W,
  parameter int SEC_PER_WEEK = DEF_SEC_PER_WEEK,
  parameter int WEEK_W       = DEF_WEEK_W,
  parameter int TFRAC_W      = DEF_TFRAC_W,
  parameter int TSEC_W       = DEF_TSEC_W,
  localparam int SEC_W       = $clog2(SEC_PER_WEEK),
  localparam int TMR_W       = TSEC_W + TFRAC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              time_ld,
  input  logic [WEEK_W-1:0] ld_week,
  input  logic [SEC_W-1:0]  ld_sec,
  input  logic [FRAC_W-1:0] ld_frac,
  input  logic              alm_wr,
  input  logic              alm_arm,
  input  logic [SEC_W-1:0]  alm_sec,
  input  logic [FRAC_W-1:0] alm_frac,
  input  logic              alm_clr,
  input  logic              tmr_ld,
  input  logic [TMR_W-1:0]  tmr_ld_val,
  input  logic              tmr_clr,
  output logic [WEEK_W-1:0] week,
  output logic [SEC_W-1:0]  sec,
  output logic [FRAC_W-1:0] frac,
  output logic              alm_flag,
  output logic [TMR_W-1:0]  tmr_val,
  output logic              tmr_flag
);

  logic adv;

  gps_rtc_tod #(
    .FRAC_W      (FRAC_W),
    .SEC_PER_WEEK(SEC_PER_WEEK),
    .SEC_W       (SEC_W),
    .WEEK_W      (WEEK_W)
  ) u_tod (
    .clk    (clk),
    .rst    (rst),
    .tick_en(tick_en),
    .ld     (time_ld),
    .ld_week(ld_week),
    .ld_sec (ld_sec),
    .ld_frac(ld_frac),
    .week   (week),
    .sec    (sec),
    .frac   (frac),
    .adv    (adv)
  );

  gps_rtc_alarm #(
    .FRAC_W(FRAC_W),
    .SEC_W (SEC_W)
  ) u_alarm (
    .clk    (clk),
    .rst    (rst),
    .adv    (adv),
    .sec    (sec),
    .frac   (frac),
    .wr     (alm_wr),
    .wr_arm (alm_arm),
    .wr_sec (alm_sec),
    .wr_frac(alm_frac),
    .clr    (alm_clr),
    .flag   (alm_flag)
  );

  gps_rtc_timer #(
    .FRAC_W (FRAC_W),
    .TFRAC_W(TFRAC_W),
    .TSEC_W (TSEC_W)
  ) u_timer (
    .clk    (clk),
    .rst    (rst),
    .tick_en(tick_en),
    .ld     (tmr_ld),
    .ld_val (tmr_ld_val),
    .clr    (tmr_clr),
    .val    (tmr_val),
    .flag   (tmr_flag)
  );

  // R1: everything is zero in the cycle after reset
  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (week == '0 && sec == '0 && frac == '0 && tmr_val == '0 && !alm_flag && !tmr_flag));

endmodule

// File: tb/gps_rtc_test.sv
module gps_rtc_test;

  localparam int CLK_PERIOD = 10;
  localparam int FRAC_MOD   = 32768;
  localparam int SEC_MOD    = 604800;
  localparam int WEEK_MOD   = 1024;

  logic        clk = 1'b0;
  logic        rst;
  logic        tick_en, time_ld, alm_wr, alm_arm, alm_clr, tmr_ld, tmr_clr;
  logic [9:0]  ld_week;
  logic [19:0] ld_sec, alm_sec;
  logic [14:0] ld_frac, alm_frac;
  logic [23:0] tmr_ld_val;
  logic [9:0]  week;
  logic [19:0] sec;
  logic [14:0] frac;
  logic        alm_flag, tmr_flag;
  logic [23:0] tmr_val;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gps_rtc uut (
    .clk(clk), .rst(rst), .tick_en(tick_en), .time_ld(time_ld),
    .ld_week(ld_week), .ld_sec(ld_sec), .ld_frac(ld_frac),
    .alm_wr(alm_wr), .alm_arm(alm_arm), .alm_sec(alm_sec), .alm_frac(alm_frac),
    .alm_clr(alm_clr), .tmr_ld(tmr_ld), .tmr_ld_val(tmr_ld_val), .tmr_clr(tmr_clr),
    .week(week), .sec(sec), .frac(frac), .alm_flag(alm_flag),
    .tmr_val(tmr_val), .tmr_flag(tmr_flag)
  );

  task automatic check(string req, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_time(string req, int w, int s, int f);
    check(req, "week", week, w);
    check(req, "sec", sec, s);
    check(req, "frac", frac, f);
  endtask

  task automatic cycle();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic ticks(int n);
    tick_en = 1'b1;
    repeat (n) cycle();
    tick_en = 1'b0;
  endtask

  task automatic load_time(int w, int s, int f, bit with_tick);
    ld_week = 10'(w); ld_sec = 20'(s); ld_frac = 15'(f);
    time_ld = 1'b1; tick_en = with_tick;
    cycle();
    time_ld = 1'b0; tick_en = 1'b0;
  endtask

  task automatic write_alarm(bit arm, int s, int f);
    alm_arm = arm; alm_sec = 20'(s); alm_frac = 15'(f); alm_wr = 1'b1;
    cycle();
    alm_wr = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int w, s, f;
    rst = 1'b1; tick_en = 0; time_ld = 0; alm_wr = 0; alm_arm = 0; alm_clr = 0;
    tmr_ld = 0; tmr_clr = 0; ld_week = '0; ld_sec = '0; ld_frac = '0;
    alm_sec = '0; alm_frac = '0; tmr_ld_val = '0;
    @(negedge clk);
    cycle(); cycle();
    rst = 1'b0;
    // R1 reset state
    check_time("R1", 0, 0, 0);
    check("R1", "tmr_val", tmr_val, 0);
    check("R1", "alm_flag", alm_flag, 0);
    check("R1", "tmr_flag", tmr_flag, 0);
    // R8: the reset alarm compare is 0/0 but disarmed; wrap onto 0 must not fire
    load_time(0, 0, 32767, 0);
    ticks(1);
    cycle(); cycle();
    check("R8", "alm_flag after wrap to compare 0", alm_flag, 0);

    // R2: single ticks and idle gaps
    load_time(0, 0, 0, 0);
    ticks(5);
    check_time("R2", 0, 0, 5);
    repeat (4) cycle();
    check_time("R2 idle", 0, 0, 5);

    // R5: load with a simultaneous tick
    load_time(77, 1234, 999, 1);
    check_time("R5", 77, 1234, 999);

    // R3: fraction carry
    load_time(5, 41, 32767, 0);
    ticks(1);
    check_time("R3", 5, 42, 0);

    // R4: seconds carry into week, and week wrap
    load_time(3, 604799, 32767, 0);
    ticks(1);
    check_time("R4", 4, 0, 0);
    load_time(1023, 604799, 32766, 0);
    ticks(1);
    check_time("R4", 1023, 604799, 32767);
    ticks(1);
    check_time("R4 week wrap", 0, 0, 0);

    // R2/R3/R4 sweep with gapped ticks across a second and a week boundary
    w = 1022; s = 604799; f = 32700;
    load_time(w, s, f, 0);
    for (int i = 0; i < 2000; i++) begin
      bit t;
      t = (i % 3) != 2;
      tick_en = t;
      cycle();
      if (t) begin
        f = f + 1;
        if (f == FRAC_MOD) begin
          f = 0; s = s + 1;
          if (s == SEC_MOD) begin s = 0; w = (w + 1) % WEEK_MOD; end
        end
      end
      check_time("R2 sweep", w, s, f);
    end
    tick_en = 0;

    // R6: armed alarm, reached by ticks
    write_alarm(1'b1, 10, 2);
    load_time(0, 10, 0, 0);
    ticks(1);
    check("R6", "alm_flag before match", alm_flag, 0);
    ticks(1);
    check("R6", "frac at match", frac, 2);
    check("R6", "alm_flag same cycle as match", alm_flag, 0);
    cycle();
    check("R6", "alm_flag one clock after match", alm_flag, 1);
    // R7 sticky, then clear
    ticks(5);
    check("R7", "alm_flag sticky", alm_flag, 1);
    alm_clr = 1; cycle(); alm_clr = 0;
    check("R7", "alm_flag cleared", alm_flag, 0);
    // R7: set and clear together, set wins
    load_time(0, 10, 1, 0);
    ticks(1);
    alm_clr = 1; cycle(); alm_clr = 0;
    check("R7", "set beats clear", alm_flag, 1);
    alm_clr = 1; cycle(); alm_clr = 0;
    // R6: reaching the value by load does not fire
    load_time(0, 10, 2, 0);
    cycle(); cycle();
    check("R6", "alm_flag after load onto compare", alm_flag, 0);
    // R8: disarmed
    write_alarm(1'b0, 10, 3);
    load_time(0, 10, 2, 0);
    ticks(1);
    cycle(); cycle();
    check("R8", "frac", frac, 3);
    check("R8", "alm_flag disarmed", alm_flag, 0);

    // R9/R10: timer of 3/256 s = 384 ticks
    tmr_ld_val = 24'h000003; tmr_ld = 1; cycle(); tmr_ld = 0;
    check("R9", "tmr_val loaded", tmr_val, 3);
    ticks(127);
    check("R9", "tmr_val before first step", tmr_val, 3);
    ticks(1);
    check("R9", "tmr_val first step", tmr_val, 2);
    ticks(255);
    check("R9", "tmr_val before last step", tmr_val, 1);
    check("R10", "tmr_flag before zero", tmr_flag, 0);
    ticks(1);
    check("R10", "tmr_val at zero", tmr_val, 0);
    check("R10", "tmr_flag at zero", tmr_flag, 1);
    ticks(300);
    check("R10", "tmr_val held", tmr_val, 0);
    check("R10", "tmr_flag sticky", tmr_flag, 1);

    // R11: load with tick restarts prescaler; R10: load keeps flag
    tmr_ld_val = 24'h000102; tmr_ld = 1; tick_en = 1; cycle(); tmr_ld = 0; tick_en = 0;
    check("R11", "tmr_val loaded with tick", tmr_val, 24'h102);
    check("R10", "tmr_flag kept over load", tmr_flag, 1);
    tmr_clr = 1; cycle(); tmr_clr = 0;
    check("R10", "tmr_flag cleared", tmr_flag, 0);
    ticks(127);
    check("R11", "tmr_val before step", tmr_val, 24'h102);
    ticks(1);
    check("R11", "tmr_val step after restart", tmr_val, 24'h101);
    // R9: borrow from seconds into fraction
    tmr_ld_val = 24'h000100; tmr_ld = 1; cycle(); tmr_ld = 0;
    ticks(128);
    check("R9", "tmr_val borrow", tmr_val, 24'h0000FF);
    check("R10", "tmr_flag not at borrow", tmr_flag, 0);

    finish_run();
  end

endmodule